// File: doc/BRIEF.md
# Fixed Power-Management Event Controller

This block holds the fixed power-management event logic of a chipset: a status register, an enable register and a control register, a free-running power-management timer, and the system control interrupt (SCI) that combines them. Software reaches it through a small word-wide register port. Each write takes one clock. Reads come back combinationally from the address currently presented.

Writing the control register with its sleep-enable bit set starts a sleep transition. The sleep-type field chooses between a soft power-off and a suspend-to-RAM. A suspend-to-RAM requests a system reset and marks the wake as if it came from the power button. A separate advanced power-management (APM) command port turns SCI mode on or off, and it can raise a system-management interrupt (SMI). A power-button pulse input and an external general-purpose event line, already masked, feed the SCI. All outputs except the SCI are single-cycle pulses.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, every register reads 0, the SCI is low and no output pulse is active.
- R2: The timer at address 3 advances by one on each clock with `tick_en` high and holds otherwise. It wraps at 2^TMR_W. It reads back zero-extended to 32 bits, and writes to address 3 have no effect.
- R3: Status bit 0 (timer overflow) is set on the tick that moves the timer onto a multiple of 2^(TMR_W-1), wrap to 0 included. It stays set until cleared, and after a clear it is set again at the next such boundary.
- R4: A write to address 0 clears each status bit written as 1 and leaves bits written as 0 unchanged. A status event arriving in the same cycle as a clear of its bit wins, and the bit stays set.
- R5: The enable register at address 1 stores and reads back the full 16-bit value written.
- R6: `sci` is high while status AND enable is non-zero in bit 0, 5, 8 or 10, or while `gpe_evt` is high. The wake bit 15 alone never raises it.
- R7: A cycle with `pwr_btn` high sets status bit 8 only when enable bit 8 is set.
- R8: A write to the control register at address 2 stores every bit except bit 13 (sleep enable), which always reads 0.
- R9: A control write with bit 13 set and sleep type (bits 12:10) equal to 0 gives a one-cycle `shutdown_req` pulse in the cycle after the write.
- R10: A control write with bit 13 set and sleep type 1 sets status bits 15 and 8. It also pulses `reset_req` and `s3_ind` for one cycle after the write.
- R11: A control write with bit 13 clear, or with a sleep type other than 0 or 1, gives no pulse and leaves the status register unchanged.
- R12: Writing 0xF1 in the low byte to the APM port at address 4 sets control bit 0 (SCI enable), 0xF0 clears it, and any other value leaves it unchanged. Address 4 reads as 0.
- R13: Any APM port write pulses `smi_pulse` for one cycle after the write when `smi_cfg_en` is high, and never when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer advance enable, one per reference-clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 32 | Read data for `bus_addr` |
| pwr_btn | input | 1 | Power-button event |
| gpe_evt | input | 1 | Masked external hotplug event line |
| smi_cfg_en | input | 1 | Configuration bit allowing SMI on APM writes |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | Soft power-off request pulse |
| reset_req | output | 1 | System reset request pulse |
| s3_ind | output | 1 | Suspend-to-RAM indication pulse |
| smi_pulse | output | 1 | System-management interrupt pulse |

## Verification
The hardest case to reach is a timer boundary that lands in the same cycle as a software clear of the overflow bit. At the default width it sits millions of ticks away. The bench therefore builds the block with a 10-bit timer, so a boundary comes every 512 ticks. It counts ticks to 1023 and then issues the clear on the very tick that wraps the counter to 0, which checks that the event wins and that the next boundary still re-arms. A reference model in the bench, written with plain integers, is compared against the outputs and the addressed register on every clock.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TIMER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_APM    = 3'd4;

  // status / enable bit positions
  localparam int B_TMR   = 0;
  localparam int B_GLBL  = 5;
  localparam int B_PWRBN = 8;
  localparam int B_RTC   = 10;
  localparam int B_WAKE  = 15;

  // control bit positions
  localparam int C_SCIEN  = 0;
  localparam int C_TYP_LO = 10;
  localparam int C_SLPEN  = 13;

  localparam logic [DATA_W-1:0] SCI_SRC_MASK =
      (16'h1 << B_TMR) | (16'h1 << B_GLBL) | (16'h1 << B_PWRBN) | (16'h1 << B_RTC);

  typedef enum logic [2:0] {
    SLP_OFF = 3'd0,
    SLP_S3  = 3'd1
  } slp_typ_e;

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] cnt_q,
  output logic             boundary
);
  localparam int LOW_W = TMR_W - 1;

  logic [TMR_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) cnt_d = cnt_q + 1'b1;
  end

  // next tick lands on a multiple of 2^(TMR_W-1)
  assign boundary = tick_en && (&cnt_q[LOW_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end

  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/pm_status.sv
module pm_status
  import pm_evt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sts_wr,
  input  logic          en_wr,
  input  logic [DW-1:0] wdata,
  input  logic          tmr_set,
  input  logic          pwr_btn,
  input  logic          wake_set,
  input  logic          gpe_evt,
  output logic [DW-1:0] sts_q,
  output logic [DW-1:0] en_q,
  output logic          sci
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] sts_d;
  logic [DW-1:0] en_d;

  always_comb begin
    set_vec = '0;
    set_vec[B_TMR]   = tmr_set;
    set_vec[B_PWRBN] = (pwr_btn && en_q[B_PWRBN]) || wake_set;
    set_vec[B_WAKE]  = wake_set;
    clr_vec = sts_wr ? wdata : '0;
  end

  // per-bit write-1-to-clear, event wins
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign sts_d[b] = set_vec[b] | (sts_q[b] & ~clr_vec[b]);
  end

  always_comb begin
    en_d = en_q;
    if (en_wr) en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sci = (|(sts_q & en_q & SCI_SRC_MASK[DW-1:0])) || gpe_evt;

  p_tmr_sts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_set |=> sts_q[B_TMR]);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[B_TMR] && !tmr_set) |=> !sts_q[B_TMR]);
  p_pwrbtn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_btn && en_q[B_PWRBN]) |=> sts_q[B_PWRBN]);
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> (sts_q[B_WAKE] && sts_q[B_PWRBN]));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_evt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          apm_wr,
  input  logic [DW-1:0] wdata,
  input  logic          smi_cfg_en,
  output logic [DW-1:0] ctrl_q,
  output logic          wake_set,
  output logic          shutdown_req,
  output logic          reset_req,
  output logic          s3_ind,
  output logic          smi_pulse
);
  logic [DW-1:0] ctrl_d;
  logic          sleep_go;
  slp_typ_e      slp_typ;
  logic          off_d, rst_d, s3_d, smi_d;

  assign sleep_go = ctrl_wr && wdata[C_SLPEN];
  assign slp_typ  = slp_typ_e'(wdata[C_TYP_LO +: 3]);
  assign wake_set = sleep_go && (slp_typ == SLP_S3);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = wdata;
      ctrl_d[C_SLPEN] = 1'b0;
    end else if (apm_wr) begin
      if (wdata[7:0] == APM_SCI_ON)       ctrl_d[C_SCIEN] = 1'b1;
      else if (wdata[7:0] == APM_SCI_OFF) ctrl_d[C_SCIEN] = 1'b0;
    end
  end

  always_comb begin
    off_d = sleep_go && (slp_typ == SLP_OFF);
    rst_d = wake_set;
    s3_d  = wake_set;
    smi_d = apm_wr && smi_cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      s3_ind       <= 1'b0;
      smi_pulse    <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_d;
      shutdown_req <= off_d;
      reset_req    <= rst_d;
      s3_ind       <= s3_d;
      smi_pulse    <= smi_d;
    end
  end

  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[C_SLPEN] && wdata[C_TYP_LO +: 3] == 3'd0) |=> shutdown_req);
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> !shutdown_req);
  p_s3_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[C_SLPEN] && wdata[C_TYP_LO +: 3] == 3'd1) |=> (reset_req && s3_ind));
  p_apm_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !ctrl_wr && wdata[7:0] == 8'hF1) |=> ctrl_q[C_SCIEN]);
  p_apm_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && !ctrl_wr && wdata[7:0] == 8'hF0) |=> !ctrl_q[C_SCIEN]);
  p_smi_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && smi_cfg_en) |=> smi_pulse);
  p_smi_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(apm_wr && smi_cfg_en) |=> !smi_pulse);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24,
  parameter int RD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [RD_W-1:0]   rd_data,
  input  logic              pwr_btn,
  input  logic              gpe_evt,
  input  logic              smi_cfg_en,
  output logic              sci,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              s3_ind,
  output logic              smi_pulse
);
  localparam int PAD_REG = RD_W - DATA_W;
  localparam int PAD_TMR = RD_W - TMR_W;

  logic              rst_n_s;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              tmr_bnd;
  logic [DATA_W-1:0] sts_q, en_q, ctrl_q;
  logic              wake_set;
  logic              sts_wr, en_wr, ctrl_wr, apm_wr;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  always_comb begin
    sts_wr  = bus_wr && (bus_addr == A_STATUS);
    en_wr   = bus_wr && (bus_addr == A_ENABLE);
    ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    apm_wr  = bus_wr && (bus_addr == A_APM);
  end

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_en (tick_en),
    .cnt_q   (tmr_cnt),
    .boundary(tmr_bnd)
  );

  pm_status #(.DW(DATA_W)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sts_wr  (sts_wr),
    .en_wr   (en_wr),
    .wdata   (bus_wdata),
    .tmr_set (tmr_bnd),
    .pwr_btn (pwr_btn),
    .wake_set(wake_set),
    .gpe_evt (gpe_evt),
    .sts_q   (sts_q),
    .en_q    (en_q),
    .sci     (sci)
  );

  pm_ctrl #(.DW(DATA_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ctrl_wr     (ctrl_wr),
    .apm_wr      (apm_wr),
    .wdata       (bus_wdata),
    .smi_cfg_en  (smi_cfg_en),
    .ctrl_q      (ctrl_q),
    .wake_set    (wake_set),
    .shutdown_req(shutdown_req),
    .reset_req   (reset_req),
    .s3_ind      (s3_ind),
    .smi_pulse   (smi_pulse)
  );

  always_comb begin
    rd_data = '0;
    unique case (bus_addr)
      A_STATUS: rd_data = {{PAD_REG{1'b0}}, sts_q};
      A_ENABLE: rd_data = {{PAD_REG{1'b0}}, en_q};
      A_CTRL:   rd_data = {{PAD_REG{1'b0}}, ctrl_q};
      A_TIMER:  rd_data = {{PAD_TMR{1'b0}}, tmr_cnt};
      default:  rd_data = '0;
    endcase
  end

  p_sci_gpe_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    gpe_evt |-> sci);
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(shutdown_req && reset_req));
endmodule

// File: tb/sim_pm_event_ctrl.sv
module sim_pm_event_ctrl;
  localparam int TW   = 10;
  localparam int HALF = 1 << (TW - 1);
  localparam int FULL = 1 << TW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic        pwr_btn = 1'b0, gpe_evt = 1'b0, smi_cfg_en = 1'b0;
  logic [31:0] rd_data;
  logic        sci, shutdown_req, reset_req, s3_ind, smi_pulse;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  pm_event_ctrl #(.TMR_W(TW), .RD_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .pwr_btn(pwr_btn), .gpe_evt(gpe_evt), .smi_cfg_en(smi_cfg_en),
    .sci(sci), .shutdown_req(shutdown_req), .reset_req(reset_req),
    .s3_ind(s3_ind), .smi_pulse(smi_pulse)
  );

  // behavioural reference model
  int m_tmr, m_sts, m_en, m_ctrl;
  bit m_off, m_rst, m_s3, m_smi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr = 0; m_sts = 0; m_en = 0; m_ctrl = 0;
      m_off = 0; m_rst = 0; m_s3 = 0; m_smi = 0;
    end else begin
      int setb, clrb;
      setb = 0; clrb = 0;
      m_off = 0; m_rst = 0; m_s3 = 0; m_smi = 0;
      if (tick_en) begin
        if ((m_tmr % HALF) == HALF - 1) setb |= 1;
        m_tmr = (m_tmr + 1) % FULL;
      end
      if (pwr_btn && m_en[8]) setb |= 'h100;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: clrb = int'(bus_wdata);
          3'd1: m_en = int'(bus_wdata);
          3'd2: begin
            m_ctrl = int'(bus_wdata) & 'hDFFF;
            if (bus_wdata[13]) begin
              if (bus_wdata[12:10] == 3'd0) m_off = 1;
              else if (bus_wdata[12:10] == 3'd1) begin
                setb |= 'h8100; m_rst = 1; m_s3 = 1;
              end
            end
          end
          3'd4: begin
            if (bus_wdata[7:0] == 8'hF1) m_ctrl |= 1;
            else if (bus_wdata[7:0] == 8'hF0) m_ctrl &= ~1;
            if (smi_cfg_en) m_smi = 1;
          end
          default: ;
        endcase
      end
      m_sts = (m_sts & ~clrb) | setb;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // cycle compare against model, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      int exp_rd;
      bit exp_sci;
      case (bus_addr)
        3'd0: exp_rd = m_sts;
        3'd1: exp_rd = m_en;
        3'd2: exp_rd = m_ctrl;
        3'd3: exp_rd = m_tmr;
        default: exp_rd = 0;
      endcase
      exp_sci = ((m_sts & m_en & 'h0521) != 0) || gpe_evt;
      chk("R6 model sci", {31'd0, sci}, {31'd0, exp_sci});
      chk("R9 model shutdown_req", {31'd0, shutdown_req}, {31'd0, m_off});
      chk("R10 model reset_req", {31'd0, reset_req}, {31'd0, m_rst});
      chk("R10 model s3_ind", {31'd0, s3_ind}, {31'd0, m_s3});
      chk("R13 model smi_pulse", {31'd0, smi_pulse}, {31'd0, m_smi});
      chk("R2 model rd_data", rd_data, exp_rd);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic ticks(int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    tick_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    running = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd("R1 reset reg", 3'(a), 32'h0);
    chk("R1 reset sci", {31'd0, sci}, 32'd0);
    chk("R1 reset pulses", {28'd0, shutdown_req, reset_req, s3_ind, smi_pulse}, 32'd0);

    // R5 enable, R7 power button, R6 sci, R4 clear
    wr(3'd1, 16'h0101);
    rd("R5 enable readback", 3'd1, 32'h0101);
    pwr_btn = 1'b1; cyc(); pwr_btn = 1'b0;
    rd("R7 pwrbtn sets status", 3'd0, 32'h0100);
    chk("R6 sci from pwrbtn", {31'd0, sci}, 32'd1);
    wr(3'd0, 16'h0001);
    rd("R4 write 0 bits keep status", 3'd0, 32'h0100);
    wr(3'd0, 16'h0100);
    rd("R4 w1c clears", 3'd0, 32'h0);
    chk("R6 sci low after clear", {31'd0, sci}, 32'd0);
    wr(3'd1, 16'h0000);
    pwr_btn = 1'b1; cyc(); pwr_btn = 1'b0;
    rd("R7 masked pwrbtn ignored", 3'd0, 32'h0);
    gpe_evt = 1'b1; #1;
    chk("R6 gpe raises sci", {31'd0, sci}, 32'd1);
    gpe_evt = 1'b0; #1;
    chk("R6 gpe release", {31'd0, sci}, 32'd0);

    // R10 suspend-to-RAM, R8 control storage
    wr(3'd2, 16'h2401);
    chk("R10 reset_req pulse", {31'd0, reset_req}, 32'd1);
    chk("R10 s3_ind pulse", {31'd0, s3_ind}, 32'd1);
    chk("R10 no shutdown", {31'd0, shutdown_req}, 32'd0);
    cyc();
    chk("R10 pulses single cycle", {30'd0, reset_req, s3_ind}, 32'd0);
    rd("R8 slp_en not stored", 3'd2, 32'h0401);
    rd("R10 wake and pwrbtn status", 3'd0, 32'h8100);
    wr(3'd1, 16'h8000);
    chk("R6 wake bit alone no sci", {31'd0, sci}, 32'd0);
    wr(3'd1, 16'h0100);
    chk("R6 pwrbtn enabled sci", {31'd0, sci}, 32'd1);
    wr(3'd0, 16'hFFFF);
    rd("R4 clear all", 3'd0, 32'h0);

    // R9 soft-off
    wr(3'd2, 16'h2000);
    chk("R9 shutdown pulse", {31'd0, shutdown_req}, 32'd1);
    chk("R9 no reset on off", {30'd0, reset_req, s3_ind}, 32'd0);
    cyc();
    chk("R9 shutdown single", {31'd0, shutdown_req}, 32'd0);

    // R11 other types / no slp_en
    wr(3'd2, 16'h3400);
    chk("R11 type5 no pulses", {29'd0, shutdown_req, reset_req, s3_ind}, 32'd0);
    rd("R11 type5 status unchanged", 3'd0, 32'h0);
    wr(3'd2, 16'h0400);
    chk("R11 no slp_en no pulses", {29'd0, shutdown_req, reset_req, s3_ind}, 32'd0);
    rd("R11 status still clear", 3'd0, 32'h0);
    rd("R8 ctrl stored", 3'd2, 32'h0400);

    // R12 / R13 APM port
    wr(3'd4, 16'h00F1);
    chk("R13 no smi when disabled", {31'd0, smi_pulse}, 32'd0);
    rd("R12 apm on sets bit0", 3'd2, 32'h0401);
    wr(3'd4, 16'h0055);
    rd("R12 other value keeps", 3'd2, 32'h0401);
    rd("R12 apm reads 0", 3'd4, 32'h0);
    smi_cfg_en = 1'b1;
    wr(3'd4, 16'h00F0);
    chk("R13 smi pulse", {31'd0, smi_pulse}, 32'd1);
    rd("R12 apm off clears bit0", 3'd2, 32'h0400);
    cyc();
    chk("R13 smi single cycle", {31'd0, smi_pulse}, 32'd0);
    smi_cfg_en = 1'b0;

    // R2 / R3 / R4 timer
    wr(3'd1, 16'h0001);
    wr(3'd3, 16'h0123);
    rd("R2 timer write ignored", 3'd3, 32'd0);
    ticks(HALF - 1);
    rd("R2 timer count", 3'd3, 32'(HALF - 1));
    rd("R3 no status before boundary", 3'd0, 32'h0);
    ticks(1);
    rd("R3 status at boundary", 3'd0, 32'h1);
    rd("R2 timer at boundary", 3'd3, 32'(HALF));
    chk("R3 timer sci", {31'd0, sci}, 32'd1);
    wr(3'd0, 16'h0001);
    rd("R3 status cleared", 3'd0, 32'h0);
    ticks(HALF - 1);
    rd("R3 no early rearm", 3'd0, 32'h0);
    tick_en = 1'b1;
    wr(3'd0, 16'h0001);
    tick_en = 1'b0;
    rd("R2 timer wraps", 3'd3, 32'd0);
    rd("R4 event wins over clear", 3'd0, 32'h1);
    wr(3'd0, 16'h0001);
    ticks(HALF);
    rd("R3 rearmed next boundary", 3'd0, 32'h1);
    rd("R2 timer after rearm", 3'd3, 32'(HALF));

    cyc();
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule